// File: doc/BRIEF.md
# Dual-Channel Serial DAC Update Sequencer

This block sits on the host side of a dual-channel serial DAC. On a start request it takes two 16-bit channel codes and a transfer mode. It then drives the converter's chip select, serial clock and serial data lines, plus its active-low load strobe. In the paired mode it writes an addressed frame for channel A and then one for channel B, with the load strobe held high. Only after the second frame does it issue a single low pulse on the load strobe, so both analog outputs change on the same event.

Three other modes are available. Two of them write one channel alone and never touch the strobe; they rely on the board holding the converter's own load input transparent. The third sends one frame with the broadcast address, carrying channel A's code, and follows it with one load pulse. The serial clock runs at a fraction of the system clock that a parameter sets. The block reports that a transfer is under way, and gives a one-cycle completion pulse.

Top module: `dacUpdateSeq`

## Requirements
- R1: Each frame is exactly 18 serial clock rising edges long and is sent most significant bit first: 2 address bits, then the 16-bit code. `dacCsN` stays low for the whole frame and goes high after the last clock to latch it.
- R2: The address field is 01 for channel A, 10 for channel B and 11 for both channels. `modeIn` encoding: 00 = paired A-then-B update, 01 = channel A only, 10 = channel B only, 11 = broadcast of `codeAIn` to both channels.
- R3: In paired mode the A frame is followed by the B frame, and `dacLoadN` stays high throughout both. Exactly one low pulse on `dacLoadN` follows, and it starts only after the second frame has ended.
- R4: In broadcast mode one frame with address 11 and the channel A code is sent, followed by exactly one `dacLoadN` low pulse.
- R5: In either single-channel mode exactly one frame is sent, and `dacLoadN` never goes low.
- R6: `dacSclk` is low whenever `dacCsN` is high. `dacSdi` never changes while `dacSclk` stays high.
- R7: At least 2*HALF_DIV system clocks separate the fall of `dacCsN` from the first `dacSclk` rise. The same minimum separates the last `dacSclk` fall from the rise of `dacCsN`.
- R8: Every `dacLoadN` low pulse lasts at least 2*HALF_DIV system clocks, and `dacCsN` is high for its whole duration.
- R9: Mode and both codes are sampled on the cycle a start is accepted. A start seen while `busy` is high is ignored, and so are later changes to the inputs.
- R10: `busy` rises in the cycle after an accepted start. `done` is high for exactly one cycle per transfer. In the modes that pulse the strobe, that cycle is the first one in which `dacLoadN` is high again. In single-channel modes it comes after `dacCsN` has returned high. `busy` falls right after `done`.
- R11: After reset `dacCsN` = 1, `dacLoadN` = 1, `dacSclk` = 0, `busy` = 0 and `done` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Transfer request, accepted when idle |
| modeIn | input | 2 | Transfer mode (see R2) |
| codeAIn | input | 16 | Channel A code |
| codeBIn | input | 16 | Channel B code |
| dacCsN | output | 1 | Active-low chip select to the converter |
| dacSclk | output | 1 | Serial clock, idles low |
| dacSdi | output | 1 | Serial data, valid on rising clock edges |
| dacLoadN | output | 1 | Active-low simultaneous-update strobe |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench decodes the serial lines the way the converter would. It rebuilds every frame from the data sampled on rising clock edges, and it times the guard intervals and the strobe pulse. A design that pulsed the strobe between the two paired frames, or after a single-channel write, would show up as a wrong strobe count or a wrong frame index at the strobe's fall. A design that shifted on the wrong clock edge, or dropped a setup interval, would corrupt the reconstructed word or trip the interval counters. Starts injected mid-transfer with altered codes target a sequencer that re-arms or re-samples its inputs: that fault shows up as extra frames, a second completion pulse or changed frame contents.

// File: rtl/dacSeqPkg.sv
package dacSeqPkg;

  typedef enum logic [1:0] {
    MODE_PAIR   = 2'b00,
    MODE_ONLY_A = 2'b01,
    MODE_ONLY_B = 2'b10,
    MODE_BCAST  = 2'b11
  } seqMode_t;

  // value equals the address field sent on the wire
  typedef enum logic [1:0] {
    SEL_A   = 2'b01,
    SEL_B   = 2'b10,
    SEL_ALL = 2'b11
  } frameSel_t;

  typedef struct packed {
    logic      capture;
    logic      frameLoad;
    frameSel_t sel;
    logic      shiftBit;
    logic      csLow;
    logic      csHigh;
    logic      clkRise;
    logic      clkFall;
    logic      ldLow;
    logic      ldHigh;
  } seqStrobes_t;

endpackage

// File: rtl/dacSeqDatapath.sv
module dacSeqDatapath
  import dacSeqPkg::*;
#(
  parameter int CODE_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobes,
  input  logic [CODE_W-1:0] codeAIn,
  input  logic [CODE_W-1:0] codeBIn,
  output logic              dacCsN,
  output logic              dacSclk,
  output logic              dacSdi,
  output logic              dacLoadN
);

  localparam int FRAME_BITS = ADDR_W + CODE_W;

  logic [CODE_W-1:0]     codeAR, codeBR;
  logic [CODE_W-1:0]     codeAUse, codeBUse, frameCode;
  logic [FRAME_BITS-1:0] shiftReg;

  // on the capture cycle the first frame is built straight from the inputs
  assign codeAUse  = strobes.capture ? codeAIn : codeAR;
  assign codeBUse  = strobes.capture ? codeBIn : codeBR;
  assign frameCode = (strobes.sel == SEL_B) ? codeBUse : codeAUse;
  assign dacSdi    = shiftReg[FRAME_BITS-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeAR   <= '0;
      codeBR   <= '0;
      shiftReg <= '0;
      dacCsN   <= 1'b1;
      dacSclk  <= 1'b0;
      dacLoadN <= 1'b1;
    end else begin
      if (strobes.capture) begin
        codeAR <= codeAIn;
        codeBR <= codeBIn;
      end
      if (strobes.frameLoad)
        shiftReg <= {ADDR_W'(strobes.sel), frameCode};
      else if (strobes.shiftBit)
        shiftReg <= {shiftReg[FRAME_BITS-2:0], 1'b0};
      if (strobes.csLow)       dacCsN <= 1'b0;
      else if (strobes.csHigh) dacCsN <= 1'b1;
      if (strobes.clkRise)      dacSclk <= 1'b1;
      else if (strobes.clkFall) dacSclk <= 1'b0;
      if (strobes.ldLow)       dacLoadN <= 1'b0;
      else if (strobes.ldHigh) dacLoadN <= 1'b1;
    end
  end

  // R6: clock idles low whenever the select is released
  p_sclk_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    dacCsN |-> !dacSclk);

  // R6: data held steady across a high clock phase
  p_sdi_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    (dacSclk && $past(dacSclk)) |-> $stable(dacSdi));

  // R8: strobe only pulses with the select released
  p_load_cs_r8: assert property (@(posedge clk) disable iff (!rstN)
    !dacLoadN |-> dacCsN);

  // R8: strobe pulse is longer than a single cycle
  p_load_width_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dacLoadN) |=> !dacLoadN);

  // R1: frame closes with the clock already low
  p_cs_close_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dacCsN) |-> !dacSclk);

endmodule

// File: rtl/dacSeqControl.sv
module dacSeqControl
  import dacSeqPkg::*;
#(
  parameter int CODE_W   = 16,
  parameter int ADDR_W   = 2,
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [1:0]  modeIn,
  output seqStrobes_t strobes,
  output logic        busy,
  output logic        done
);

  localparam int FRAME_BITS = ADDR_W + CODE_W;
  localparam int LAST_STEP  = 2 * FRAME_BITS - 2;
  localparam int SW         = $clog2(2 * FRAME_BITS);
  localparam int DW         = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_SHIFT, S_HOLD, S_GAP, S_LOAD, S_DONE
  } seqState_t;

  seqState_t state, stateNx;
  seqMode_t  modeR, modeNx;
  logic [SW-1:0] stepCnt, stepNx;
  logic [DW-1:0] divCnt;
  logic          frameIdx, frameNx;
  logic          tick;

  assign tick = (divCnt == DW'(HALF_DIV - 1));
  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);

  function automatic frameSel_t firstSel(input seqMode_t m);
    case (m)
      MODE_ONLY_B: firstSel = SEL_B;
      MODE_BCAST:  firstSel = SEL_ALL;
      default:     firstSel = SEL_A;
    endcase
  endfunction

  always_comb begin
    strobes = '0;
    stateNx = state;
    stepNx  = stepCnt;
    frameNx = frameIdx;
    modeNx  = modeR;
    case (state)
      S_IDLE: if (start) begin
        modeNx            = seqMode_t'(modeIn);
        strobes.capture   = 1'b1;
        strobes.frameLoad = 1'b1;
        strobes.sel       = firstSel(seqMode_t'(modeIn));
        strobes.csLow     = 1'b1;
        stepNx            = '0;
        frameNx           = 1'b0;
        stateNx           = S_SETUP;
      end
      S_SETUP: if (tick) begin
        if (stepCnt == SW'(1)) begin
          strobes.clkRise = 1'b1;
          stepNx          = '0;
          stateNx         = S_SHIFT;
        end else stepNx = stepCnt + 1'b1;
      end
      S_SHIFT: if (tick) begin
        if (stepCnt == SW'(LAST_STEP)) begin
          strobes.clkFall = 1'b1;
          stepNx          = '0;
          stateNx         = S_HOLD;
        end else begin
          if (stepCnt[0]) strobes.clkRise = 1'b1;
          else begin
            strobes.clkFall  = 1'b1;
            strobes.shiftBit = 1'b1;
          end
          stepNx = stepCnt + 1'b1;
        end
      end
      S_HOLD: if (tick) begin
        if (stepCnt == SW'(1)) begin
          strobes.csHigh = 1'b1;
          stepNx         = '0;
          stateNx        = S_GAP;
        end else stepNx = stepCnt + 1'b1;
      end
      S_GAP: if (tick) begin
        if (stepCnt == SW'(1)) begin
          stepNx = '0;
          if (modeR == MODE_PAIR && !frameIdx) begin
            strobes.frameLoad = 1'b1;
            strobes.sel       = SEL_B;
            strobes.csLow     = 1'b1;
            frameNx           = 1'b1;
            stateNx           = S_SETUP;
          end else if (modeR == MODE_PAIR || modeR == MODE_BCAST) begin
            strobes.ldLow = 1'b1;
            stateNx       = S_LOAD;
          end else stateNx = S_DONE;
        end else stepNx = stepCnt + 1'b1;
      end
      S_LOAD: if (tick) begin
        if (stepCnt == SW'(1)) begin
          strobes.ldHigh = 1'b1;
          stepNx         = '0;
          stateNx        = S_DONE;
        end else stepNx = stepCnt + 1'b1;
      end
      S_DONE:  stateNx = S_IDLE;
      default: stateNx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      modeR    <= MODE_PAIR;
      stepCnt  <= '0;
      frameIdx <= 1'b0;
      divCnt   <= '0;
    end else begin
      state    <= stateNx;
      modeR    <= modeNx;
      stepCnt  <= stepNx;
      frameIdx <= frameNx;
      if (state == S_IDLE || tick) divCnt <= '0;
      else                         divCnt <= divCnt + 1'b1;
    end
  end

  // R5: single-channel transfers never request a strobe pulse
  p_single_noload_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.ldLow |-> (modeR == MODE_PAIR || modeR == MODE_BCAST));

  // R10: completion is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: a request during a transfer leaves the sampled mode alone
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> $stable(modeR));

  // R1: the shift register is only reloaded with the select being pulled low
  p_load_with_cs_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobes.frameLoad |-> strobes.csLow);

endmodule

// File: rtl/dacUpdateSeq.sv
module dacUpdateSeq
  import dacSeqPkg::*;
#(
  parameter int CODE_W   = 16,
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        modeIn,
  input  logic [CODE_W-1:0] codeAIn,
  input  logic [CODE_W-1:0] codeBIn,
  output logic              dacCsN,
  output logic              dacSclk,
  output logic              dacSdi,
  output logic              dacLoadN,
  output logic              busy,
  output logic              done
);

  localparam int ADDR_W = 2;

  seqStrobes_t strobes;

  dacSeqControl #(
    .CODE_W(CODE_W), .ADDR_W(ADDR_W), .HALF_DIV(HALF_DIV)
  ) i_control (
    .clk(clk), .rstN(rstN), .start(start), .modeIn(modeIn),
    .strobes(strobes), .busy(busy), .done(done)
  );

  dacSeqDatapath #(
    .CODE_W(CODE_W), .ADDR_W(ADDR_W)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .codeAIn(codeAIn), .codeBIn(codeBIn),
    .dacCsN(dacCsN), .dacSclk(dacSclk), .dacSdi(dacSdi), .dacLoadN(dacLoadN)
  );

endmodule

// File: tb/test_dacUpdateSeq.sv
module test_dacUpdateSeq;

  localparam int HALF = 2;
  localparam int CW   = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [CW-1:0] codeA = '0, codeB = '0;
  logic csN, sclk, sdi, loadN, busy, done;

  dacUpdateSeq #(.CODE_W(CW), .HALF_DIV(HALF)) i_dacUpdateSeq (
    .clk(clk), .rstN(rstN), .start(start), .modeIn(mode),
    .codeAIn(codeA), .codeBIn(codeB),
    .dacCsN(csN), .dacSclk(sclk), .dacSdi(sdi), .dacLoadN(loadN),
    .busy(busy), .done(done)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- bus monitor ----------------
  int cyc = 0;
  int csFallCyc = 0, lastFallCyc = 0, loadFallCyc = 0;
  bit firstRise = 0;
  logic [17:0] shiftBuf = '0;
  int bitsIn = 0;
  logic [17:0] frm [64];
  int frmBits [64];
  int nFrames = 0, loadFalls = 0, loadFallFrames = 0, doneCount = 0;
  int idleViol = 0, sdiViol = 0, setupViol = 0, holdViol = 0;
  int loadViol = 0, csDuringLoad = 0, doneViol = 0;
  bit doneWithLoadRise = 0, doneCsHigh = 0;
  logic prevCs = 1'b1, prevSclk = 1'b0, prevSdi = 1'b0, prevLoad = 1'b1, prevDone = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (csN && sclk) idleViol++;
      if (sclk && prevSclk && sdi != prevSdi) sdiViol++;
      if (!csN && prevCs) begin
        csFallCyc = cyc; firstRise = 1; bitsIn = 0; shiftBuf = '0;
      end
      if (sclk && !prevSclk) begin
        if (firstRise && (cyc - csFallCyc) < 2 * HALF) setupViol++;
        firstRise = 0;
        shiftBuf = {shiftBuf[16:0], sdi};
        bitsIn++;
      end
      if (!sclk && prevSclk) lastFallCyc = cyc;
      if (csN && !prevCs) begin
        if ((cyc - lastFallCyc) < 2 * HALF) holdViol++;
        frm[nFrames % 64] = shiftBuf;
        frmBits[nFrames % 64] = bitsIn;
        nFrames++;
      end
      if (!loadN && prevLoad) begin
        loadFalls++; loadFallFrames = nFrames; loadFallCyc = cyc;
      end
      if (!loadN && !csN) csDuringLoad++;
      if (loadN && !prevLoad && (cyc - loadFallCyc) < 2 * HALF) loadViol++;
      if (done) begin
        doneCount++;
        if (prevDone) doneViol++;
        doneWithLoadRise = loadN && !prevLoad;
        doneCsHigh = csN;
      end
    end
    prevCs = csN; prevSclk = sclk; prevSdi = sdi; prevLoad = loadN; prevDone = done;
  end

  // ---------------- reference model ----------------
  function automatic logic [17:0] expFrame(input logic [1:0] m, input int idx,
                                           input logic [15:0] a, input logic [15:0] b);
    case (m)
      2'b00:   expFrame = (idx == 0) ? {2'b01, a} : {2'b10, b};
      2'b01:   expFrame = {2'b01, a};
      2'b10:   expFrame = {2'b10, b};
      default: expFrame = {2'b11, a};
    endcase
  endfunction

  function automatic string frameReq(input logic [1:0] m);
    if (m == 2'b00) frameReq = "R3";
    else if (m == 2'b11) frameReq = "R4";
    else frameReq = "R2";
  endfunction

  task automatic runTxn(input logic [1:0] m, input logic [15:0] a,
                        input logic [15:0] b, input bit inject);
    int baseF = nFrames;
    int baseL = loadFalls;
    int baseD = doneCount;
    int nf = (m == 2'b00) ? 2 : 1;
    int expLoads = (m == 2'b00 || m == 2'b11) ? 1 : 0;
    int w = 0;
    @(negedge clk);
    mode = m; codeA = a; codeB = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R10", "busy after start", busy, 1);
    // R9: input changes after acceptance must not matter
    codeA = ~a; codeB = ~b; mode = ~m;
    if (inject) begin
      repeat (30) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (doneCount == baseD && w < 5000) begin
      @(negedge clk);
      w++;
    end
    repeat (6) @(negedge clk);
    check(doneCount == baseD + 1, "R10", "done pulses", doneCount - baseD, 1);
    check(busy == 1'b0, "R10", "busy after done", busy, 0);
    check(nFrames == baseF + nf, inject ? "R9" : "R5", "frame count", nFrames - baseF, nf);
    for (int i = 0; i < nf; i++) begin
      check(frm[(baseF + i) % 64] == expFrame(m, i, a, b), frameReq(m), "frame word",
            frm[(baseF + i) % 64], expFrame(m, i, a, b));
      check(frmBits[(baseF + i) % 64] == 18, "R1", "clock edges per frame",
            frmBits[(baseF + i) % 64], 18);
    end
    check(loadFalls == baseL + expLoads, (expLoads != 0) ? "R3" : "R5", "strobe pulses",
          loadFalls - baseL, expLoads);
    if (expLoads != 0) begin
      check(loadFallFrames == baseF + nf, (m == 2'b00) ? "R3" : "R4",
            "frames done at strobe fall", loadFallFrames - baseF, nf);
      check(doneWithLoadRise, "R10", "done with strobe release", doneWithLoadRise, 1);
    end else begin
      check(doneCsHigh, "R10", "select high at done", doneCsHigh, 1);
    end
    check(idleViol == 0 && sdiViol == 0, "R6", "clock idle / data stability faults",
          idleViol + sdiViol, 0);
    check(setupViol == 0 && holdViol == 0, "R7", "select guard faults",
          setupViol + holdViol, 0);
    check(loadViol == 0 && csDuringLoad == 0, "R8", "strobe pulse faults",
          loadViol + csDuringLoad, 0);
    check(doneViol == 0, "R10", "done longer than one cycle", doneViol, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog expired: actual %0d expected %0d", checks, 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // R11: reset state
    check(csN == 1'b1, "R11", "select after reset", csN, 1);
    check(loadN == 1'b1, "R11", "strobe after reset", loadN, 1);
    check(sclk == 1'b0, "R11", "clock after reset", sclk, 0);
    check(busy == 1'b0 && done == 1'b0, "R11", "busy/done after reset", {busy, done}, 0);

    // directed corners
    runTxn(2'b00, 16'hFFFF, 16'h0000, 0);
    runTxn(2'b00, 16'h0000, 16'hFFFF, 0);
    runTxn(2'b01, 16'h8001, 16'h1234, 0);
    runTxn(2'b10, 16'h5A5A, 16'hA5A5, 0);
    runTxn(2'b11, 16'h1234, 16'hBEEF, 0);
    runTxn(2'b00, 16'hC3C3, 16'h3C3C, 1);
    runTxn(2'b10, 16'h0F0F, 16'hF0F0, 1);
    runTxn(2'b11, 16'h7FFF, 16'h8000, 1);

    // constrained random
    for (int n = 0; n < 40; n++) begin
      runTxn(2'($urandom_range(0, 3)), 16'($urandom), 16'($urandom),
             ($urandom_range(0, 3) == 0));
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule